// File: doc/BRIEF.md
# Serial EEPROM Device-Address Matcher

This block is the front end of a two-wire serial EEPROM slave. It watches the clock line and the data line on a system clock and finds bus START and STOP conditions. After every START, including a repeated START sent without a STOP before it, it collects the first eight bits the master sends. It then decides whether that byte selects this device.

A byte selects the device when two things are true. Its upper nibble must be the fixed memory family code `1010`. Its next three bits must equal the levels on three board-strapped chip-select inputs. On a match the block does four things: it raises a one-cycle hit pulse, it records the direction bit, it pulls the data line low for the acknowledge clock, and it then waits for the next bus condition. On a mismatch it goes back to standby and leaves the data line alone until the next START. Downstream logic uses the hit pulse and the direction flag to begin a read or a write transfer.

Top module: `eeprom_addr_match`

## Requirements
- R1: While reset is high and in the cycle after it falls, `addr_hit_o`, `rd_nwr_o` and `sda_oe_o` are all 0.
- R2: A START is SDA falling while SCL is high, with both lines seen after the synchronizer. It begins address reception, and address bits are taken MSB first on each rising SCL edge.
- R3: After the eighth rising SCL edge, `addr_hit_o` pulses high for exactly one cycle when bits [7:4] are `1010` and bits [3:1] equal `chip_sel_i[2:0]` (bit 3 against `chip_sel_i[2]`). Otherwise it stays 0.
- R4: `rd_nwr_o` takes the value of bit 0 of a matching byte (1 = read, 0 = write). It changes only together with a hit pulse and keeps its value across mismatches.
- R5: After a match, `sda_oe_o` is 1 from the falling SCL edge that ends the eighth bit to the falling SCL edge that ends the ninth clock, and 0 at all other times.
- R6: A byte that fails either the family-code compare or the chip-select compare produces no hit pulse and no `sda_oe_o`. Later SCL clocks are ignored until a new START.
- R7: A repeated START at any point, including partway through an address byte, discards the bits collected so far and restarts reception from the first bit.
- R8: A STOP (SDA rising while SCL is high) returns the block to standby. Eight clocked bits that follow a STOP without a new START give no hit and no `sda_oe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level (asynchronous) |
| sda_i | input | 1 | Bus data line level (asynchronous) |
| chip_sel_i | input | 3 | Strapped device-select levels, compared with address bits [3:1] |
| addr_hit_o | output | 1 | One-cycle pulse when an address byte selects this device |
| rd_nwr_o | output | 1 | Direction of the last matching address, 1 = read |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low for the acknowledge |

## Verification
The hardest case to reach from the ports is a repeated START that arrives partway through an address byte. The leftover bits and the bit count must both be thrown away, or the next byte lines up wrongly and gives a false hit or a missed hit. The bench sends four bits, issues a repeated START with SCL low, and then sends a whole matching byte, expecting exactly one hit and one acknowledge. It also drives the acknowledge clock on the shared open-drain line model, so the device sees its own pull-down on `sda_i`. This confirms that releasing the line does not look like a bus condition.

// File: rtl/eeam_pkg.sv
package eeam_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned SEL_W     = 3;
    localparam int unsigned FAMILY_W  = BYTE_W - SEL_W - 1;
    localparam int unsigned CNT_W     = $clog2(BYTE_W + 1);
    localparam logic [FAMILY_W-1:0] FAMILY_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK,
        ST_HOLD
    } eng_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda_lvl;
    } bus_ev_t;

    function automatic logic addr_selects(input logic [BYTE_W-1:0] addr_byte,
                                          input logic [SEL_W-1:0]  sel);
        return (addr_byte[BYTE_W-1 -: FAMILY_W] == FAMILY_CODE) &&
               (addr_byte[SEL_W:1] == sel);
    endfunction

endpackage

// File: rtl/eeam_sync.sv
module eeam_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= {W{RST_VAL}};
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/eeam_bus_cond.sv
module eeam_bus_cond
    import eeam_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev_o.start    = scl_q & scl_s & sda_q & ~sda_s;
        ev_o.stop     = scl_q & scl_s & ~sda_q & sda_s;
        ev_o.scl_rise = ~scl_q & scl_s;
        ev_o.scl_fall = scl_q & ~scl_s;
        ev_o.sda_lvl  = sda_s;
    end
endmodule

// File: rtl/eeam_addr_engine.sv
module eeam_addr_engine
    import eeam_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             hit_o,
    output logic             rd_nwr_o,
    output logic             oe_o
);
    eng_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] next_byte;
    logic              last_bit;

    assign next_byte = {shreg[BYTE_W-2:0], ev_i.sda_lvl};
    assign last_bit  = (bit_cnt == CNT_W'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            hit_o    <= 1'b0;
            rd_nwr_o <= 1'b0;
            oe_o     <= 1'b0;
        end else begin
            hit_o <= 1'b0;
            if (ev_i.start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                shreg   <= '0;
                oe_o    <= 1'b0;
            end else if (ev_i.stop) begin
                state <= ST_IDLE;
                oe_o  <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: if (ev_i.scl_rise) begin
                        shreg   <= next_byte;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (last_bit) begin
                            if (addr_selects(next_byte, sel_i)) begin
                                hit_o    <= 1'b1;
                                rd_nwr_o <= next_byte[0];
                                state    <= ST_ACK_WAIT;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK_WAIT: if (ev_i.scl_fall) begin
                        oe_o  <= 1'b1;
                        state <= ST_ACK;
                    end
                    ST_ACK: if (ev_i.scl_fall) begin
                        oe_o  <= 1'b0;
                        state <= ST_HOLD;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: a hit lasts a single cycle and follows a rising SCL edge
    p_hit_single_r3: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> !hit_o);
    p_hit_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> $past(ev_i.scl_rise));
    // R4: direction flag moves only with a hit
    p_dir_with_hit_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_nwr_o) |-> hit_o);
    // R5: acknowledge drive begins and ends on SCL falling edges or bus conditions
    p_oe_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_o) |-> $past(ev_i.scl_fall));
    p_oe_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_o) |-> $past(ev_i.scl_fall || ev_i.stop || ev_i.start));
    // R7: any start restarts reception from bit zero
    p_start_restart_r7: assert property (@(posedge clk) disable iff (rst)
        ev_i.start |=> (state == ST_ADDR && bit_cnt == '0 && !oe_o));
    // R8: a stop releases the line and idles the engine
    p_stop_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_i.stop && !ev_i.start) |=> (state == ST_IDLE && !oe_o));
endmodule

// File: rtl/eeprom_addr_match.sv
module eeprom_addr_match
    import eeam_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [SEL_W-1:0] chip_sel_i,
    output logic             addr_hit_o,
    output logic             rd_nwr_o,
    output logic             sda_oe_o
);
    logic [1:0] line_s;
    bus_ev_t    ev;

    eeam_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({scl_i, sda_i}),
        .q_o (line_s)
    );

    eeam_bus_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (line_s[1]),
        .sda_s (line_s[0]),
        .ev_o  (ev)
    );

    eeam_addr_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .ev_i     (ev),
        .sel_i    (chip_sel_i),
        .hit_o    (addr_hit_o),
        .rd_nwr_o (rd_nwr_o),
        .oe_o     (sda_oe_o)
    );

    // R6: no drive on the line without a preceding hit since the last start
    logic armed;
    always_ff @(posedge clk) begin
        if (rst || ev.start || ev.stop) armed <= 1'b0;
        else if (addr_hit_o)            armed <= 1'b1;
    end
    p_oe_needs_hit_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> armed);
endmodule

// File: tb/test_eeprom_addr_match.sv
module test_eeprom_addr_match;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0] sel = 3'b010;
    logic hit, rdnwr, oe;
    logic sda_bus;

    int vectors = 0, errors = 0;
    int hits_seen = 0, oe_cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign sda_bus = sda_m & ~oe;

    eeprom_addr_match i_eeprom_addr_match (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .chip_sel_i(sel), .addr_hit_o(hit), .rd_nwr_o(rdnwr), .sda_oe_o(oe)
    );

    // Behavioural reference model
    int   m_state;   // 0 idle, 1 addr, 2 wait ack, 3 ack, 4 hold
    int   m_cnt;
    logic [7:0] m_byte;
    logic m_hit, m_rw, m_oe;
    logic m_c1, m_c2, m_cp, m_d1, m_d2, m_dp;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_cnt = 0; m_byte = 0;
            m_hit = 0; m_rw = 0; m_oe = 0;
            m_c1 = 1; m_c2 = 1; m_cp = 1; m_d1 = 1; m_d2 = 1; m_dp = 1;
        end else begin
            m_hit = 0;
            if (m_cp && m_c2 && m_dp && !m_d2) begin
                m_state = 1; m_cnt = 0; m_byte = 0; m_oe = 0;
            end else if (m_cp && m_c2 && !m_dp && m_d2) begin
                m_state = 0; m_oe = 0;
            end else if (m_state == 1 && !m_cp && m_c2) begin
                m_byte = {m_byte[6:0], m_d2};
                m_cnt++;
                if (m_cnt == 8) begin
                    if (m_byte[7:4] == 4'b1010 && m_byte[3:1] == sel) begin
                        m_hit = 1; m_rw = m_byte[0]; m_state = 2;
                    end else m_state = 0;
                end
            end else if (m_state == 2 && m_cp && !m_c2) begin
                m_oe = 1; m_state = 3;
            end else if (m_state == 3 && m_cp && !m_c2) begin
                m_oe = 0; m_state = 4;
            end
            m_cp = m_c2; m_c2 = m_c1; m_c1 = scl_m;
            m_dp = m_d2; m_d2 = m_d1; m_d1 = sda_bus;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R3 hit vs model", hit, m_hit);
            check("R4 rw vs model", rdnwr, m_rw);
            check("R5 oe vs model", oe, m_oe);
            if (hit) hits_seen++;
            if (oe) oe_cycles++;
        end
    end

    task automatic wait_q(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1; wait_q(); scl_m = 1; wait_q();
        sda_m = 0; wait_q(); scl_m = 0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 0; wait_q(); scl_m = 1; wait_q(); sda_m = 1; wait_q();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_q(); scl_m = 1; wait_q(); scl_m = 0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    // Address byte + ninth clock, then judge hit count and ack drive
    task automatic xfer(input string req, input logic [7:0] v, input int exp_hit);
        hits_seen = 0; oe_cycles = 0;
        send_byte(v);
        send_bit(1'b1);
        check_int({req, " hit count"}, hits_seen, exp_hit);
        check_int({req, " ack driven"}, (oe_cycles > 0) ? 1 : 0, exp_hit);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 hit in reset", hit, 1'b0);
        check("R1 rw in reset", rdnwr, 1'b0);
        check("R1 oe in reset", oe, 1'b0);
        rst = 0;
        @(negedge clk);
        check("R1 hit after reset", hit, 1'b0);
        check("R1 oe after reset", oe, 1'b0);

        // R2 R3 R5: write address matches straps 010
        bus_start();
        xfer("R3 write match", 8'b1010_010_0, 1);
        check("R4 write dir", rdnwr, 1'b0);
        // R7 R4: repeated start, read address
        bus_start();
        xfer("R7 restart read match", 8'b1010_010_1, 1);
        check("R4 read dir", rdnwr, 1'b1);
        bus_stop();

        // R6: family code wrong
        bus_start();
        xfer("R6 family mismatch", 8'b1011_010_0, 0);
        check("R4 dir kept after mismatch", rdnwr, 1'b1);
        // R6: clocks after mismatch ignored
        xfer("R6 ignored after mismatch", 8'b1010_010_0, 0);
        // R6: chip select wrong
        bus_start();
        xfer("R6 select mismatch", 8'b1010_011_0, 0);
        bus_stop();

        // R7: repeated start partway through a byte
        bus_start();
        send_bit(1); send_bit(0); send_bit(1); send_bit(0);
        bus_start();
        xfer("R7 restart mid-byte", 8'b1010_010_0, 1);
        check("R4 dir after mid restart", rdnwr, 1'b0);
        bus_stop();

        // R8: bits after stop with no start
        xfer("R8 no start after stop", 8'b1010_010_1, 0);
        check("R8 dir untouched", rdnwr, 1'b0);

        // R3: different strap pattern; old address now misses
        sel = 3'b111;
        repeat (4) @(negedge clk);
        bus_start();
        xfer("R3 old select misses", 8'b1010_010_1, 0);
        bus_start();
        xfer("R3 new select read", 8'b1010_111_1, 1);
        check("R4 dir read strap 111", rdnwr, 1'b1);
        bus_stop();
        sel = 3'b000;
        repeat (4) @(negedge clk);
        bus_start();
        xfer("R3 select 000 write", 8'b1010_000_0, 1);
        check("R4 dir write strap 000", rdnwr, 1'b0);
        bus_stop();
        repeat (10) @(negedge clk);
        check("R5 oe idle at end", oe, 1'b0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule